// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block drives a byte-wide multiplexed external memory bus on behalf of a processor core. It counts in oscillator periods: one clock of `clk` is one oscillator period, and a machine cycle is 12 periods. The machine cycle splits into two halves of 6 periods. In a fetch-only machine cycle, each half latches the core's fetch address, gives it out on the bus, pulses the address latch strobe and the program-store read strobe, and returns the captured instruction byte to the core.

When the core asks for a data access, the next machine cycle becomes a data cycle. It has a single address latch pulse, no program-store strobes and one read or write strobe. The high port shows either the upper byte of a 16-bit data pointer or, for an 8-bit data address, a register value supplied by the core. An optional protected mode clears the top address bits on the high port, which confines external code and data space to the low 4K.

Top module: `xbus_seq`

## Requirements
- R1: A machine cycle is 12 clock periods, and phase 0 starts on the first rising edge after reset is released. In a fetch cycle `ale` is high in phases 0-1 and 6-7 and low otherwise: two pulses per cycle, 6 periods apart, each 2 periods wide.
- R2: In a fetch cycle `psen_n` is low in phases 3-5 and 9-11, which starts one period after `ale` falls and lasts 3 periods.
- R3: In a fetch cycle the low port drives (`bus_lo_oe`=1) bits 7:0 of the fetch address in phases 0-2 and 6-8, and floats in the psen phases. The high port shows bits 15:8 of that address for the whole half. `fetch_addr` is sampled on the edge that opens each half.
- R4: The instruction byte is sampled from `bus_lo_in` on the edge where `psen_n` rises. `instr_valid` is then high for exactly the next period, with that byte on `instr_byte`.
- R5: `data_req` is sampled on the edge that ends phase 11; when it is 1 the following cycle is a data cycle. In a data cycle `ale` is high only in phases 0-1 and `psen_n` stays high for all 12 periods.
- R6: In a data cycle the access strobe (`wr_n` if `data_write`=1, else `rd_n`) is low in phases 5-10, which is 6 periods starting 3 periods after `ale` falls. The other access strobe stays high. At most one of `psen_n`, `rd_n` and `wr_n` is low at any time.
- R7: In a data cycle the low port drives `data_addr[7:0]` in phases 0-2. The high port shows `data_addr[15:8]` when `data_wide`=1, or the `hi_reg` value when `data_wide`=0, for all 12 periods. All data request fields are sampled together with `data_req`.
- R8: In a write cycle the low port drives the sampled `wr_data` in phases 3-11. That is from two periods before `wr_n` falls until one period after it rises.
- R9: In a read cycle the low port floats in phases 3-11. The byte is sampled on the edge where `rd_n` rises. `data_done` is high in phase 11 of every data cycle, and for reads `data_byte` then holds the sampled byte.
- R10: While `protect_en` is 1 at an edge, the port value registered on that edge has `bus_hi[7:4]` forced to 0. This holds for fetch addresses, 16-bit data addresses and the `hi_reg` value.
- R11: While `rst_n` is low: `ale`=0, `psen_n`=`rd_n`=`wr_n`=1, `bus_lo_oe`=0, `bus_hi`=0, `instr_valid`=0 and `data_done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| protect_en | input | 1 | Clear high address bits 15:12 on the high port |
| fetch_addr | input | 16 | Code address, sampled at each half-cycle start |
| data_req | input | 1 | Make the next machine cycle a data cycle |
| data_write | input | 1 | 1 = write access, 0 = read access |
| data_wide | input | 1 | 1 = 16-bit data address, 0 = 8-bit |
| data_addr | input | 16 | Data address |
| wr_data | input | 8 | Byte to write |
| hi_reg | input | 8 | High port value for 8-bit data accesses |
| bus_lo_in | input | 8 | Low port input from the pads |
| bus_lo_out | output | 8 | Low port output value |
| bus_lo_oe | output | 1 | Low port output enable |
| bus_hi | output | 8 | High port value |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program-store read strobe |
| rd_n | output | 1 | Data read strobe |
| wr_n | output | 1 | Data write strobe |
| instr_valid | output | 1 | One-period pulse: instruction byte captured |
| instr_byte | output | 8 | Captured instruction byte |
| data_done | output | 1 | One-period pulse at the end of a data cycle |
| data_byte | output | 8 | Captured read byte |

## Verification
The assertions rely on the core holding `protect_en` steady across at least one edge before its effect is judged. They also rely on each request field staying constant from its setup to the phase-11 edge that samples it. The bench meets both conditions by changing every input only on falling clock edges. It also changes the request fields only in phase 11 and the fetch address only at half-cycle boundaries. The stimulus mixes fetch cycles with back-to-back reads and writes of both address widths, and toggles protected mode in the middle of bus traffic.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    // Machine cycle layout in oscillator periods.
    localparam int PH_N      = 12;
    localparam int HALF      = 6;
    localparam int ALE_LEN   = 2;
    localparam int ADDR_LAST = 2;
    localparam int PS_FIRST  = 3;
    localparam int PS_LAST   = 5;
    localparam int STB_FIRST = 5;
    localparam int STB_LAST  = 10;
    localparam int WD_FIRST  = 3;
    localparam int PH_W      = $clog2(PH_N);

    typedef logic [PH_W-1:0] phase_t;

    typedef struct packed {
        logic ale;
        logic psen_n;
        logic rd_n;
        logic wr_n;
        logic drv_addr;
        logic drv_wdata;
    } slot_ctl_t;
endpackage

// File: rtl/xbus_phase_ctr.sv
module xbus_phase_ctr
    import xbus_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_t phase_q,
    output phase_t phase_nxt
);
    phase_t phase_d;

    always_comb begin
        if (phase_q == phase_t'(PH_N - 1)) phase_d = '0;
        else                               phase_d = phase_q + phase_t'(1);
    end

    assign phase_nxt = phase_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= phase_t'(PH_N - 1);
        else        phase_q <= phase_d;
    end
endmodule

// File: rtl/xbus_slot_decode.sv
module xbus_slot_decode
    import xbus_pkg::*;
(
    input  phase_t    slot,
    input  logic      is_data,
    input  logic      is_write,
    output slot_ctl_t ctl
);
    always_comb begin
        int p;
        int o;
        logic stb;
        p   = int'(slot);
        o   = p % HALF;
        stb = 1'b0;
        ctl = '{ale: 1'b0, psen_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1,
                drv_addr: 1'b0, drv_wdata: 1'b0};
        if (!is_data) begin
            // Both halves repeat the same address/fetch pattern.
            for (int h = 0; h < PH_N / HALF; h++) begin
                if (p >= h * HALF && p < h * HALF + ALE_LEN) ctl.ale = 1'b1;
                if (p >= h * HALF + PS_FIRST && p <= h * HALF + PS_LAST) ctl.psen_n = 1'b0;
            end
            ctl.drv_addr = (o <= ADDR_LAST);
        end else begin
            ctl.ale       = (p < ALE_LEN);
            ctl.drv_addr  = (p <= ADDR_LAST);
            stb           = (p >= STB_FIRST) && (p <= STB_LAST);
            ctl.rd_n      = !(stb && !is_write);
            ctl.wr_n      = !(stb && is_write);
            ctl.drv_wdata = is_write && (p >= WD_FIRST);
        end
    end
endmodule

// File: rtl/xbus_hi_mux.sv
module xbus_hi_mux #(
    parameter int DW        = 8,
    parameter int PROT_BITS = 4
) (
    input  logic [DW-1:0] raw,
    input  logic          protect_en,
    output logic [DW-1:0] hi
);
    for (genvar b = 0; b < DW; b++) begin : g_bit
        if (b >= DW - PROT_BITS) begin : g_guarded
            assign hi[b] = raw[b] & ~protect_en;
        end else begin : g_open
            assign hi[b] = raw[b];
        end
    end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int DW        = 8,
    parameter int PROT_BITS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          protect_en,
    input  logic [2*DW-1:0] fetch_addr,
    input  logic          data_req,
    input  logic          data_write,
    input  logic          data_wide,
    input  logic [2*DW-1:0] data_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] hi_reg,
    input  logic [DW-1:0] bus_lo_in,
    output logic [DW-1:0] bus_lo_out,
    output logic          bus_lo_oe,
    output logic [DW-1:0] bus_hi,
    output logic          ale,
    output logic          psen_n,
    output logic          rd_n,
    output logic          wr_n,
    output logic          instr_valid,
    output logic [DW-1:0] instr_byte,
    output logic          data_done,
    output logic [DW-1:0] data_byte
);
    localparam int AW = 2 * DW;

    // Request fields held for the current machine cycle / half.
    typedef struct packed {
        logic          is_data;
        logic          is_write;
        logic          wide;
        logic [AW-1:0] daddr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] hreg;
        logic [AW-1:0] faddr;
    } req_t;

    // Registered bus outputs and core returns.
    typedef struct packed {
        logic          ale;
        logic          psen_n;
        logic          rd_n;
        logic          wr_n;
        logic [DW-1:0] lo_out;
        logic          lo_oe;
        logic [DW-1:0] hi;
        logic          ivld;
        logic [DW-1:0] ibyte;
        logic          ddone;
        logic [DW-1:0] dbyte;
    } out_t;

    localparam out_t OUT_RST = '{ale: 1'b0, psen_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1,
                                 lo_out: '0, lo_oe: 1'b0, hi: '0, ivld: 1'b0,
                                 ibyte: '0, ddone: 1'b0, dbyte: '0};

    req_t      r_q, r_d;
    out_t      o_q, o_d;
    phase_t    phase_q, phase_nxt;
    slot_ctl_t ctl;
    logic [DW-1:0] hi_raw, hi_prot;

    xbus_phase_ctr u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_q   (phase_q),
        .phase_nxt (phase_nxt)
    );

    // Sample requests: data fields at cycle start, fetch address at half start.
    always_comb begin
        r_d = r_q;
        if (phase_q == phase_t'(PH_N - 1)) begin
            r_d.is_data = data_req;
            if (data_req) begin
                r_d.is_write = data_write;
                r_d.wide     = data_wide;
                r_d.daddr    = data_addr;
                r_d.wdata    = wr_data;
                r_d.hreg     = hi_reg;
            end
        end
        if (int'(phase_nxt) % HALF == 0) r_d.faddr = fetch_addr;
    end

    xbus_slot_decode u_decode (
        .slot     (phase_nxt),
        .is_data  (r_d.is_data),
        .is_write (r_d.is_write),
        .ctl      (ctl)
    );

    always_comb begin
        if (!r_d.is_data)   hi_raw = r_d.faddr[AW-1:DW];
        else if (r_d.wide)  hi_raw = r_d.daddr[AW-1:DW];
        else                hi_raw = r_d.hreg;
    end

    xbus_hi_mux #(.DW(DW), .PROT_BITS(PROT_BITS)) u_hi (
        .raw        (hi_raw),
        .protect_en (protect_en),
        .hi         (hi_prot)
    );

    always_comb begin
        o_d        = o_q;
        o_d.ale    = ctl.ale;
        o_d.psen_n = ctl.psen_n;
        o_d.rd_n   = ctl.rd_n;
        o_d.wr_n   = ctl.wr_n;
        o_d.hi     = hi_prot;
        o_d.lo_oe  = ctl.drv_addr | ctl.drv_wdata;
        if (ctl.drv_addr)       o_d.lo_out = r_d.is_data ? r_d.daddr[DW-1:0] : r_d.faddr[DW-1:0];
        else if (ctl.drv_wdata) o_d.lo_out = r_d.wdata;
        // Captures use the cycle that is ending at this edge.
        o_d.ivld  = 1'b0;
        o_d.ddone = 1'b0;
        if (!r_q.is_data && (int'(phase_q) % HALF == PS_LAST)) begin
            o_d.ivld  = 1'b1;
            o_d.ibyte = bus_lo_in;
        end
        if (r_q.is_data && (int'(phase_q) == STB_LAST)) begin
            o_d.ddone = 1'b1;
            if (!r_q.is_write) o_d.dbyte = bus_lo_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
            o_q <= OUT_RST;
        end else begin
            r_q <= r_d;
            o_q <= o_d;
        end
    end

    assign ale         = o_q.ale;
    assign psen_n      = o_q.psen_n;
    assign rd_n        = o_q.rd_n;
    assign wr_n        = o_q.wr_n;
    assign bus_lo_out  = o_q.lo_out;
    assign bus_lo_oe   = o_q.lo_oe;
    assign bus_hi      = o_q.hi;
    assign instr_valid = o_q.ivld;
    assign instr_byte  = o_q.ibyte;
    assign data_done   = o_q.ddone;
    assign data_byte   = o_q.dbyte;
endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk #(
    parameter int DW        = 8,
    parameter int PROT_BITS = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          protect_en,
    input logic          ale,
    input logic          psen_n,
    input logic          rd_n,
    input logic          wr_n,
    input logic          bus_lo_oe,
    input logic [DW-1:0] bus_hi
);
    p_ale_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |=> ale ##1 !ale);

    p_psen_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(psen_n) |-> !$past(ale) && $past(ale, 2));

    p_strobe_lag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_n) || $fell(wr_n)) |-> !$past(ale, 3) && $past(ale, 4));

    p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);

    p_read_float_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !bus_lo_oe);

    p_wr_setup_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n) |-> $past(bus_lo_oe));

    p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> bus_lo_oe);

    p_prot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(protect_en) |-> bus_hi[DW-1 -: PROT_BITS] == '0);
endmodule

bind xbus_seq xbus_seq_chk #(.DW(DW), .PROT_BITS(PROT_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .protect_en (protect_en),
    .ale        (ale),
    .psen_n     (psen_n),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .bus_lo_oe  (bus_lo_oe),
    .bus_hi     (bus_hi)
);

// File: tb/xbus_seq_tb.sv
module xbus_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RUN_MCYC   = 800;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic protect_en = 1'b0;
    logic [15:0] fetch_addr = 16'h0000;
    logic data_req = 1'b0, data_write = 1'b0, data_wide = 1'b0;
    logic [15:0] data_addr = 16'h0000;
    logic [7:0]  wr_data = 8'h00, hi_reg = 8'h00, bus_lo_in = 8'h00;
    logic [7:0]  bus_lo_out, bus_hi, instr_byte, data_byte;
    logic bus_lo_oe, ale, psen_n, rd_n, wr_n, instr_valid, data_done;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;
    logic [31:0] lf = 32'h1234_5678;

    xbus_seq u_dut (
        .clk(clk), .rst_n(rst_n), .protect_en(protect_en), .fetch_addr(fetch_addr),
        .data_req(data_req), .data_write(data_write), .data_wide(data_wide),
        .data_addr(data_addr), .wr_data(wr_data), .hi_reg(hi_reg), .bus_lo_in(bus_lo_in),
        .bus_lo_out(bus_lo_out), .bus_lo_oe(bus_lo_oe), .bus_hi(bus_hi), .ale(ale),
        .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .instr_valid(instr_valid),
        .instr_byte(instr_byte), .data_done(data_done), .data_byte(data_byte)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [31:0] step_lf(input logic [31:0] v);
        return {v[30:0], 1'b0} ^ (v[31] ? 32'h04C1_1DB7 : 32'h0);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // Behavioural model: phase number, cycle kind and latched request.
    int mph = 11;
    bit mdat = 0, mwr = 0, mwide = 0;
    logic [15:0] mdaddr = 0, mfaddr = 0;
    logic [7:0]  mwd = 0, mhr = 0;
    bit e_ale = 0, e_psen = 1, e_rd = 1, e_wr = 1, e_oe = 0, e_iv = 0, e_dd = 0;
    logic [7:0] e_lo = 0, e_hi = 0, e_ib = 0, e_db = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mph = 11; mdat = 0; mwr = 0; mwide = 0; mdaddr = 0; mfaddr = 0; mwd = 0; mhr = 0;
            e_ale = 0; e_psen = 1; e_rd = 1; e_wr = 1; e_oe = 0; e_hi = 0;
            e_iv = 0; e_dd = 0; e_ib = 0; e_db = 0;
        end else begin
            e_iv = 0;
            e_dd = 0;
            if (!mdat && (mph == 5 || mph == 11)) begin e_iv = 1; e_ib = bus_lo_in; end
            if (mdat && mph == 10) begin e_dd = 1; if (!mwr) e_db = bus_lo_in; end
            mph = (mph + 1) % 12;
            if (mph == 0) begin
                mdat = data_req;
                if (data_req) begin
                    mwr = data_write; mwide = data_wide; mdaddr = data_addr;
                    mwd = wr_data; mhr = hi_reg;
                end
            end
            if (mph % 6 == 0) mfaddr = fetch_addr;
            if (!mdat) begin
                e_ale  = (mph % 6) < 2;
                e_psen = !((mph % 6) >= 3);
                e_rd = 1; e_wr = 1;
                e_oe = (mph % 6) <= 2;
                e_lo = mfaddr[7:0];
                e_hi = mfaddr[15:8];
            end else begin
                e_ale  = mph < 2;
                e_psen = 1;
                e_rd   = !(mph >= 5 && mph <= 10 && !mwr);
                e_wr   = !(mph >= 5 && mph <= 10 && mwr);
                if (mph <= 2) begin e_oe = 1; e_lo = mdaddr[7:0]; end
                else if (mwr) begin e_oe = 1; e_lo = mwd; end
                else e_oe = 0;
                e_hi = mwide ? mdaddr[15:8] : mhr;
            end
            if (protect_en) e_hi[7:4] = 4'h0;
        end
    end

    // Compare away from the active edge, then drive the next inputs.
    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                chk("R11", "ale in reset", ale, 0);
                chk("R11", "psen_n in reset", psen_n, 1);
                chk("R11", "rd_n in reset", rd_n, 1);
                chk("R11", "wr_n in reset", wr_n, 1);
                chk("R11", "lo_oe in reset", bus_lo_oe, 0);
                chk("R11", "hi in reset", bus_hi, 0);
                chk("R11", "valids in reset", {instr_valid, data_done}, 0);
            end else begin
                chk(mdat ? "R5" : "R1", "ale", ale, e_ale);
                chk(mdat ? "R5" : "R2", "psen_n", psen_n, e_psen);
                chk("R6", "rd_n", rd_n, e_rd);
                chk("R6", "wr_n", wr_n, e_wr);
                chk(mdat ? (mwr ? "R8" : "R9") : "R3", "lo_oe", bus_lo_oe, e_oe);
                if (e_oe) chk(mdat ? (mwr && mph > 2 ? "R8" : "R7") : "R3", "lo_out", bus_lo_out, e_lo);
                chk(protect_en ? "R10" : (mdat ? "R7" : "R3"), "hi", bus_hi, e_hi);
                chk("R4", "instr_valid", instr_valid, e_iv);
                if (e_iv) chk("R4", "instr_byte", instr_byte, e_ib);
                chk("R9", "data_done", data_done, e_dd);
                if (e_dd && !mwr) chk("R9", "data_byte", data_byte, e_db);
            end
        end
        lf = step_lf(lf);
        bus_lo_in = lf[15:8];
        if (mph == 11 || mph == 5) fetch_addr = lf[31:16] ^ lf[15:0];
        if (mph == 11) begin
            case (lf[26:24] % 6)
                0, 1: data_req = 0;
                2: begin data_req = 1; data_write = 0; data_wide = 1; end
                3: begin data_req = 1; data_write = 0; data_wide = 0; end
                4: begin data_req = 1; data_write = 1; data_wide = 1; end
                default: begin data_req = 1; data_write = 1; data_wide = 0; end
            endcase
            data_addr = lf[23:8];
            wr_data   = lf[7:0] ^ 8'h5A;
            hi_reg    = lf[31:24];
        end
        if (mph == 3 && lf[4:0] == 5'd7) protect_en = !protect_en;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (RUN_MCYC * 12) @(posedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule